// File: doc/BRIEF.md
# Quasi-Bidirectional Port Pin Controller

This block produces the pad drive enables for a port of general-purpose pins that has no direction register. The bus interface hands it a new 16-bit port value together with a one-cycle update strobe. For every pin the block holds that value and derives three enables from it: a strong pull-down, a weak pull-up and a short strong pull-up boost. A pin that holds 1 is only weakly pulled high. An outside device can therefore pull it low, and the pin serves as an input with no separate configuration step.

The boost lets a heavily loaded line rise fast after it is written high. The bus interface also supplies a one-cycle pulse for each falling edge of its serial clock, and that pulse ends the boost. On the input side, every pad value passes through a two-flop synchronizer. The synchronized values feed port reads, and a per-pin change pulse is raised when a synchronized value toggles.

Top module: `qbio_port_ctrl`

## Requirements
- R1: After a synchronous reset, every pin is held high. `weak_up_en` is all ones, `pull_dn_en` and `boost_up_en` are all zeros, `pin_rd` is all ones and `pin_edge` is all zeros.
- R2: In the cycle after `wr_stb`, a pin written 1 has `weak_up_en`=1 and `pull_dn_en`=0. A pin written 0 has `pull_dn_en`=1 and `weak_up_en`=0. An external driver forcing such a pin high is then a contention.
- R3: While `wr_stb` is 0, `wr_data` has no effect on any enable.
- R4: In the cycle after `wr_stb`, `boost_up_en` equals the written word. Bit i is 1 for every pin written 1, whether the pin was previously 0 or already 1, and 0 for every pin written 0.
- R5: A `scl_fall` pulse without `wr_stb` clears every bit of `boost_up_en` in the next cycle.
- R6: When `wr_stb` and `scl_fall` fall in the same cycle, the write wins. `boost_up_en` takes the written word, and the next `scl_fall` clears it.
- R7: For every pin, `pull_dn_en` and `boost_up_en` are never 1 together.
- R8: `pin_rd` equals `pin_in` delayed by two clock cycles.
- R9: `pin_edge[i]` is 1 for exactly one cycle, in the same cycle that `pin_rd[i]` takes a new value. This applies to both rising and falling changes.
- R10: With neither `wr_stb` nor `scl_fall` present, `boost_up_en` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_stb | input | 1 | One-cycle strobe: load `wr_data` into the port latch |
| wr_data | input | 16 | New port value; bit i belongs to pin i |
| scl_fall | input | 1 | One-cycle pulse per falling serial-clock edge |
| pin_in | input | 16 | Raw pad levels |
| pull_dn_en | output | 16 | Strong pull-down enable per pin |
| weak_up_en | output | 16 | Weak pull-up enable per pin |
| boost_up_en | output | 16 | Momentary strong pull-up enable per pin |
| pin_rd | output | 16 | Synchronized pad levels for reads |
| pin_edge | output | 16 | One-cycle pulse per pin when `pin_rd` changes |

## Verification
Two boost events can land in the same cycle: the update strobe that starts a boost and the falling-clock pulse that ends one. The stimulus table includes a row that raises `wr_stb` and `scl_fall` together. The result is judged by whether `boost_up_en` shows the new word in the next cycle rather than zeros, and whether a later lone `scl_fall` still clears it. The bench pad model also drives a pin high while that pin is latched low, and the contention it flags is checked.

// File: rtl/qbio_pkg.sv
package qbio_pkg;

    localparam int unsigned QB_PINS        = 16;
    localparam int unsigned QB_SYNC_STAGES = 2;

    typedef struct packed {
        logic pull_dn;
        logic weak_up;
        logic boost_up;
    } pin_drive_t;

    typedef struct packed {
        logic lat;
        logic boost;
    } pin_state_t;

    function automatic pin_drive_t drive_of(pin_state_t st);
        pin_drive_t d;
        d.pull_dn  = ~st.lat;
        d.weak_up  = st.lat;
        d.boost_up = st.boost;
        return d;
    endfunction

endpackage

// File: rtl/qbio_out_latch.sv
module qbio_out_latch #(
    parameter int unsigned N = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_stb,
    input  logic [N-1:0] wr_data,
    input  logic         scl_fall,
    output logic [N-1:0] lat_q,
    output logic [N-1:0] boost_q
);

    localparam logic [N-1:0] ALL_ONE  = {N{1'b1}};
    localparam logic [N-1:0] ALL_ZERO = {N{1'b0}};

    always_ff @(posedge clk) begin
        if (rst) begin
            lat_q <= ALL_ONE;
        end else if (wr_stb) begin
            lat_q <= wr_data;
        end
    end

    // write has priority over the falling-clock cutoff
    always_ff @(posedge clk) begin
        if (rst) begin
            boost_q <= ALL_ZERO;
        end else if (wr_stb) begin
            boost_q <= wr_data;
        end else if (scl_fall) begin
            boost_q <= ALL_ZERO;
        end
    end

    assert_hold_no_strobe_R3: assert property (@(posedge clk) disable iff (rst)
        !wr_stb |=> $stable(lat_q));

    assert_boost_follows_write_R4: assert property (@(posedge clk) disable iff (rst)
        wr_stb |=> boost_q == $past(wr_data));

    assert_boost_cut_R5: assert property (@(posedge clk) disable iff (rst)
        (scl_fall && !wr_stb) |=> boost_q == ALL_ZERO);

    assert_boost_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (!scl_fall && !wr_stb) |=> $stable(boost_q));

endmodule

// File: rtl/qbio_in_sync.sv
module qbio_in_sync #(
    parameter int unsigned N      = 16,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] pin_raw,
    output logic [N-1:0] pin_sync,
    output logic [N-1:0] pin_edge
);

    localparam int unsigned LAST = STAGES - 1;
    localparam logic [N-1:0] ALL_ONE = {N{1'b1}};

    logic [N-1:0] stage_q [STAGES];
    logic [N-1:0] prev_q;
    logic         armed_q;

    always_ff @(posedge clk) begin
        if (rst) stage_q[0] <= ALL_ONE;
        else     stage_q[0] <= pin_raw;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stage_q[s] <= ALL_ONE;
            else     stage_q[s] <= stage_q[s-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q  <= ALL_ONE;
            armed_q <= 1'b0;
        end else begin
            prev_q  <= stage_q[LAST];
            armed_q <= 1'b1;
        end
    end

    assign pin_sync = stage_q[LAST];
    assign pin_edge = stage_q[LAST] ^ prev_q;

    assert_edge_marks_change_R9: assert property (@(posedge clk) disable iff (rst)
        armed_q |-> pin_edge == (pin_sync ^ $past(pin_sync)));

endmodule

// File: rtl/qbio_pin_drive.sv
module qbio_pin_drive
    import qbio_pkg::*;
#(
    parameter int unsigned N = 16
) (
    input  logic [N-1:0] lat,
    input  logic [N-1:0] boost,
    output logic [N-1:0] pull_dn,
    output logic [N-1:0] weak_up,
    output logic [N-1:0] boost_up
);

    for (genvar i = 0; i < N; i++) begin : g_pin
        pin_state_t st;
        pin_drive_t dr;
        assign st.lat   = lat[i];
        assign st.boost = boost[i];
        assign dr       = drive_of(st);
        assign pull_dn[i]  = dr.pull_dn;
        assign weak_up[i]  = dr.weak_up;
        assign boost_up[i] = dr.boost_up;
    end

endmodule

// File: rtl/qbio_port_ctrl.sv
module qbio_port_ctrl
    import qbio_pkg::*;
#(
    parameter int unsigned N      = QB_PINS,
    parameter int unsigned STAGES = QB_SYNC_STAGES
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_stb,
    input  logic [N-1:0] wr_data,
    input  logic         scl_fall,
    input  logic [N-1:0] pin_in,
    output logic [N-1:0] pull_dn_en,
    output logic [N-1:0] weak_up_en,
    output logic [N-1:0] boost_up_en,
    output logic [N-1:0] pin_rd,
    output logic [N-1:0] pin_edge
);

    logic [N-1:0] lat_q;
    logic [N-1:0] boost_q;

    qbio_out_latch #(.N(N)) u_latch (
        .clk      (clk),
        .rst      (rst),
        .wr_stb   (wr_stb),
        .wr_data  (wr_data),
        .scl_fall (scl_fall),
        .lat_q    (lat_q),
        .boost_q  (boost_q)
    );

    qbio_pin_drive #(.N(N)) u_drive (
        .lat      (lat_q),
        .boost    (boost_q),
        .pull_dn  (pull_dn_en),
        .weak_up  (weak_up_en),
        .boost_up (boost_up_en)
    );

    qbio_in_sync #(.N(N), .STAGES(STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .pin_raw  (pin_in),
        .pin_sync (pin_rd),
        .pin_edge (pin_edge)
    );

    assert_no_pull_fight_R7: assert property (@(posedge clk) disable iff (rst)
        (pull_dn_en & boost_up_en) == '0);

    assert_write_drive_R2: assert property (@(posedge clk) disable iff (rst)
        wr_stb |=> pull_dn_en == ~$past(wr_data));

endmodule

// File: tb/tb_qbio_port_ctrl.sv
`timescale 1ns/1ps
module tb_qbio_port_ctrl;

    localparam int N = 16;

    logic         clk = 1'b0;
    logic         rst;
    logic         wr_stb;
    logic [N-1:0] wr_data;
    logic         scl_fall;
    logic [N-1:0] pin_in;
    logic [N-1:0] pull_dn_en, weak_up_en, boost_up_en, pin_rd, pin_edge;

    // pad model: external driver wins, else pull-down, else pull-up/keeper
    logic [N-1:0] ext_en, ext_val, pad, contention;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    qbio_port_ctrl dut (
        .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_data(wr_data),
        .scl_fall(scl_fall), .pin_in(pin_in),
        .pull_dn_en(pull_dn_en), .weak_up_en(weak_up_en),
        .boost_up_en(boost_up_en), .pin_rd(pin_rd), .pin_edge(pin_edge)
    );

    always_comb begin
        for (int i = 0; i < N; i++) begin
            if (ext_en[i])          pad[i] = ext_val[i];
            else if (pull_dn_en[i]) pad[i] = 1'b0;
            else                    pad[i] = 1'b1;
        end
        contention = (ext_en & ext_val & pull_dn_en) | (ext_en & ~ext_val & boost_up_en);
    end
    assign pin_in = pad;

    typedef struct packed {
        logic         wr;
        logic         scl;
        logic [N-1:0] data;
        logic [N-1:0] exp_pd;
        logic [N-1:0] exp_boost;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 1'b0, 16'h00FF, 16'hFF00, 16'h00FF},  // R2 R4 first write
        '{1'b0, 1'b0, 16'h1234, 16'hFF00, 16'h00FF},  // R3 R10 data ignored, boost held
        '{1'b0, 1'b1, 16'h0000, 16'hFF00, 16'h0000},  // R5 cutoff
        '{1'b1, 1'b1, 16'h0F0F, 16'hF0F0, 16'h0F0F},  // R6 write wins over cutoff
        '{1'b1, 1'b0, 16'hFFFF, 16'h0000, 16'hFFFF},  // R4 rewrite of ones
        '{1'b1, 1'b0, 16'hA5A5, 16'h5A5A, 16'hA5A5},  // R4 zeros drop boost
        '{1'b0, 1'b1, 16'h0000, 16'h5A5A, 16'h0000},  // R5
        '{1'b1, 1'b0, 16'h0000, 16'hFFFF, 16'h0000}   // R2 all low
    };

    task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic check_reset_state(input string tag);
        chk({tag, " R1 weak_up"}, weak_up_en, '1);
        chk({tag, " R1 pull_dn"}, pull_dn_en, '0);
        chk({tag, " R1 boost"},   boost_up_en, '0);
        chk({tag, " R1 pin_rd"},  pin_rd, '1);
        chk({tag, " R1 pin_edge"}, pin_edge, '0);
    endtask

    initial begin
        #1_000_000;
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst = 1'b1; wr_stb = 1'b0; wr_data = '0; scl_fall = 1'b0;
        ext_en = '0; ext_val = '0;
        repeat (3) tick();
        rst = 1'b0;
        tick();
        check_reset_state("power-on");

        // table walk: drive at negedge, result visible after the next posedge
        for (int v = 0; v < NV; v++) begin
            wr_stb = VECS[v].wr; scl_fall = VECS[v].scl; wr_data = VECS[v].data;
            tick();
            chk($sformatf("R2 vec%0d pull_dn", v), pull_dn_en, VECS[v].exp_pd);
            chk($sformatf("R2 vec%0d weak_up", v), weak_up_en, ~VECS[v].exp_pd);
            chk($sformatf("R4 R5 R6 vec%0d boost", v), boost_up_en, VECS[v].exp_boost);
            chk($sformatf("R7 vec%0d overlap", v), pull_dn_en & boost_up_en, '0);
        end
        wr_stb = 1'b0; scl_fall = 1'b0;

        // R6 follow-up: boost set by the combined cycle is cut by a later pulse
        wr_stb = 1'b1; scl_fall = 1'b1; wr_data = 16'h8001;
        tick();
        wr_stb = 1'b0; scl_fall = 1'b0;
        chk("R6 combined cycle boost", boost_up_en, 16'h8001);
        tick();
        chk("R10 boost held", boost_up_en, 16'h8001);
        scl_fall = 1'b1;
        tick();
        scl_fall = 1'b0;
        chk("R6 later cutoff", boost_up_en, '0);

        // all pins released high for input use
        wr_stb = 1'b1; wr_data = '1;
        tick();
        wr_stb = 1'b0; scl_fall = 1'b1;
        tick();
        scl_fall = 1'b0;
        repeat (3) tick();

        // R8 R9 external pull-low on pin 3
        ext_en[3] = 1'b1; ext_val[3] = 1'b0;
        tick();
        chk("R8 one cycle: still old", pin_rd, 16'hFFFF);
        chk("R9 no edge yet", pin_edge, '0);
        tick();
        chk("R8 two cycles: new value", pin_rd, 16'hFFF7);
        chk("R9 falling edge pulse", pin_edge, 16'h0008);
        tick();
        chk("R9 pulse lasts one cycle", pin_edge, '0);
        ext_en[3] = 1'b0;
        tick();
        tick();
        chk("R8 released pin back high", pin_rd, 16'hFFFF);
        chk("R9 rising edge pulse", pin_edge, 16'h0008);
        tick();
        chk("R9 rising pulse ends", pin_edge, '0);

        // R2 contention: pin latched low, external device drives it high
        wr_stb = 1'b1; wr_data = 16'h0000;
        tick();
        wr_stb = 1'b0;
        repeat (2) tick();
        chk("R8 pulled-down pins read low", pin_rd, 16'h0000);
        ext_en[5] = 1'b1; ext_val[5] = 1'b1;
        #1;
        chk("R2 contention flagged", contention, 16'h0020);
        ext_en = '0;
        #1;
        chk("R2 contention gone", contention, '0);

        // mid-run reset
        wr_stb = 1'b1; wr_data = 16'h3C3C;
        tick();
        wr_stb = 1'b0;
        rst = 1'b1;
        tick();
        rst = 1'b0;
        check_reset_state("mid-run");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule